// File: doc/BRIEF.md
# Spread Spectrum Depth Selector and Triangle Profile Generator

This block chooses how far a clock synthesiser spreads its output frequency and produces the matching modulation profile. The result is a signed offset word that a fractional divider adds to its nominal ratio. The offset starts at zero, ramps down to the selected depth, and ramps back. It never goes above zero, so the average frequency always stays at or below nominal.

The default depth comes from a three-level board strap. The strap is sampled once, at the first power-good indication. Software can replace the strapped depth by setting an override enable together with a two-bit depth code. The captured strap value can always be read back. A pulse on the modulation tick input advances the triangle by one step. The number of steps per ramp is the same at every depth, so the modulation period depends only on the tick rate. A newly requested depth takes effect only when the profile is back at zero offset. This avoids any jump in frequency.

Top module: `ssc_depth_sel`

## Requirements
- R1: After reset the offset is 0, the applied depth code is 00 and the strap readback is 00.
- R2: On the first cycle in which power-good is high, the strap level is captured. Level encodings are 00 low, 01 mid, 10 high; 11 is treated as low. The readback becomes 00 for low, 01 for mid and 11 for high one cycle later. Until the capture, the strapped depth is off.
- R3: Power-good pulses after the first capture are ignored: the readback and the strapped depth keep their captured values.
- R4: While the override enable is 0, the software depth code has no effect. The applied depth follows the strap: low gives off (00), mid gives -0.25% (01), high gives -0.5% (11).
- R5: While the override enable is 1, the software code selects the depth: 00 gives off, 01 gives -0.25% and 11 gives -0.5%. The reserved code 10 gives off (00).
- R6: With a non-off depth, the offset after k ticks from zero is -(t(k) * M * STEP_LSB). Here t rises by one per tick from 0 to RAMP_STEPS, falls back to 0, and repeats with a period of 2*RAMP_STEPS ticks. M is 1 for -0.25% and 2 for -0.5%. The offset changes in the cycle after the tick and nowhere else.
- R7: The offset is never positive. Its magnitude never exceeds RAMP_STEPS * 2 * STEP_LSB.
- R8: A change in the requested depth while the offset is non-zero is held back. The old depth stays applied until the profile returns to zero, and the new depth is applied on the following cycle.
- R9: While the applied depth is off, the offset stays 0 regardless of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_lvl_i | input | 2 | Decoded strap level (00 low, 01 mid, 10 high) |
| pwr_good_i | input | 1 | Power-good indication; its first high cycle captures the strap |
| sw_ovr_en_i | input | 1 | Software override enable |
| sw_depth_i | input | 2 | Software depth code |
| mod_tick_i | input | 1 | One-cycle pulse that advances the triangle one step |
| strap_rb_o | output | 2 | Captured strap readback |
| depth_o | output | 2 | Currently applied depth code |
| offset_o | output | OFF_W | Signed frequency offset word (zero or negative) |

## Verification
The in-RTL assertions check on every cycle that the offset stays at or below zero and within the deepest bound. They also check that the step counter moves only on a tick, that the applied depth is frozen while the offset is away from zero, and that the captured strap never changes after capture. The bench scenarios are the only way to show the rest. These are the exact ramp values over whole periods at each depth, the decoding of every strap level and software code (including the reserved code), the priority of the override over the strap, and the cycle in which a held-back depth change finally lands.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        SS_OFF  = 2'b00,
        SS_QTR  = 2'b01,
        SS_HALF = 2'b11
    } ss_depth_e;

    function automatic ss_depth_e strap_to_depth(input logic [1:0] lvl);
        case (lvl)
            2'b01:   return SS_QTR;
            2'b10:   return SS_HALF;
            default: return SS_OFF;
        endcase
    endfunction

    function automatic ss_depth_e sw_to_depth(input logic [1:0] code);
        case (code)
            2'b01:   return SS_QTR;
            2'b11:   return SS_HALF;
            default: return SS_OFF;
        endcase
    endfunction

    function automatic logic [1:0] depth_mult(input ss_depth_e d);
        case (d)
            SS_QTR:  return 2'd1;
            SS_HALF: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ssc_strap_latch.sv
module ssc_strap_latch
    import ssc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_lvl_i,
    input  logic       pwr_good_i,
    output ss_depth_e  strap_depth_o
);

    typedef struct packed {
        logic      taken;
        ss_depth_e depth;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.taken && pwr_good_i) begin
            st_d.taken = 1'b1;
            st_d.depth = strap_to_depth(strap_lvl_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{taken: 1'b0, depth: SS_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign strap_depth_o = st_q.depth;

    assert_strap_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.taken |=> (st_q.taken && $stable(st_q.depth)));

    assert_uncaptured_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.taken |-> st_q.depth == SS_OFF);

endmodule

// File: rtl/ssc_depth_arb.sv
module ssc_depth_arb
    import ssc_pkg::*;
(
    input  ss_depth_e  strap_depth_i,
    input  logic       sw_ovr_en_i,
    input  logic [1:0] sw_depth_i,
    output ss_depth_e  req_depth_o
);

    always_comb begin
        if (sw_ovr_en_i) begin
            req_depth_o = sw_to_depth(sw_depth_i);
        end else begin
            req_depth_o = strap_depth_i;
        end
    end

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_pkg::*;
#(
    parameter int RAMP_STEPS = 16,
    parameter int STEP_LSB   = 8,
    parameter int OFF_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  ss_depth_e               req_depth_i,
    input  logic                    tick_i,
    output ss_depth_e               depth_o,
    output logic signed [OFF_W-1:0] offset_o
);

    localparam int CW = $clog2(RAMP_STEPS + 1);
    localparam logic [CW-1:0] PEAK = CW'(RAMP_STEPS);
    localparam int MAX_MAG = RAMP_STEPS * 2 * STEP_LSB;

    typedef struct packed {
        ss_depth_e     mode;
        logic [CW-1:0] cnt;
        logic          down;
    } tri_t;

    tri_t st_d, st_q;
    logic [OFF_W-1:0] mag;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.mode = req_depth_i;
            st_d.down = 1'b0;
            if (tick_i && req_depth_i != SS_OFF) begin
                st_d.cnt  = CW'(1);
                st_d.down = (PEAK == CW'(1));
            end
        end else if (tick_i) begin
            if (!st_q.down) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt + 1'b1 == PEAK) begin
                    st_d.down = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == CW'(1)) begin
                    st_d.down = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: SS_OFF, cnt: '0, down: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mag      = OFF_W'(st_q.cnt) * OFF_W'(depth_mult(st_q.mode)) * OFF_W'(STEP_LSB);
        offset_o = -$signed(mag);
    end

    assign depth_o = st_q.mode;

    assert_offset_nonpos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        offset_o <= 0);

    assert_offset_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(offset_o) >= -MAX_MAG);

    assert_step_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.cnt));

    assert_count_peak_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= PEAK);

    assert_depth_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.mode));

endmodule

// File: rtl/ssc_depth_sel.sv
module ssc_depth_sel
    import ssc_pkg::*;
#(
    parameter int RAMP_STEPS = 16,
    parameter int STEP_LSB   = 8,
    parameter int OFF_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              strap_lvl_i,
    input  logic                    pwr_good_i,
    input  logic                    sw_ovr_en_i,
    input  logic [1:0]              sw_depth_i,
    input  logic                    mod_tick_i,
    output logic [1:0]              strap_rb_o,
    output logic [1:0]              depth_o,
    output logic signed [OFF_W-1:0] offset_o
);

    ss_depth_e strap_depth;
    ss_depth_e req_depth;
    ss_depth_e applied;

    ssc_strap_latch u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_lvl_i   (strap_lvl_i),
        .pwr_good_i    (pwr_good_i),
        .strap_depth_o (strap_depth)
    );

    ssc_depth_arb u_arb (
        .strap_depth_i (strap_depth),
        .sw_ovr_en_i   (sw_ovr_en_i),
        .sw_depth_i    (sw_depth_i),
        .req_depth_o   (req_depth)
    );

    ssc_tri_gen #(
        .RAMP_STEPS (RAMP_STEPS),
        .STEP_LSB   (STEP_LSB),
        .OFF_W      (OFF_W)
    ) u_tri (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_depth_i (req_depth),
        .tick_i      (mod_tick_i),
        .depth_o     (applied),
        .offset_o    (offset_o)
    );

    assign strap_rb_o = 2'(strap_depth);
    assign depth_o    = 2'(applied);

    assert_reserved_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ovr_en_i && sw_depth_i == 2'b10) |-> req_depth == SS_OFF);

endmodule

// File: tb/tb_ssc_depth_sel.sv
module tb_ssc_depth_sel;

    localparam int N     = 16;
    localparam int STEP  = 8;
    localparam int OFF_W = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] strap_lvl;
    logic pwr_good;
    logic sw_en;
    logic [1:0] sw_code;
    logic tick;
    logic [1:0] strap_rb;
    logic [1:0] depth;
    logic signed [OFF_W-1:0] offset;

    int checks = 0;
    int errors = 0;
    int phase  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ssc_depth_sel #(.RAMP_STEPS(N), .STEP_LSB(STEP), .OFF_W(OFF_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_lvl_i (strap_lvl),
        .pwr_good_i  (pwr_good),
        .sw_ovr_en_i (sw_en),
        .sw_depth_i  (sw_code),
        .mod_tick_i  (tick),
        .strap_rb_o  (strap_rb),
        .depth_o     (depth),
        .offset_o    (offset)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tri_at(input int k);
        int p = k % (2 * N);
        return (p <= N) ? p : (2 * N - p);
    endfunction

    function automatic int rb_of(input int lvl);
        case (lvl)
            1: return 1;
            2: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int mult_of(input int code);
        case (code)
            1: return 1;
            3: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ramp(input int n, input int mult, input string tag);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            phase++;
            chk(tag, int'(offset), -(tri_at(phase) * mult * STEP));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pwr_good = 1'b0;
        tick = 1'b0;
        sw_en = 1'b0;
        sw_code = 2'b00;
        phase = 0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic strobe();
        pwr_good = 1'b1;
        step();
        pwr_good = 1'b0;
    endtask

    initial begin
        strap_lvl = 2'b00;
        do_reset();
        // R1 reset state
        chk("R1 offset", int'(offset), 0);
        chk("R1 depth", int'(depth), 0);
        chk("R1 readback", int'(strap_rb), 0);
        // R2 uncaptured strap is off; R9 ticks give no offset
        strap_lvl = 2'b10;
        ramp(3, 0, "R9 before capture");
        chk("R2 depth before capture", int'(depth), 0);

        // R2, R6: every strap level, a full period each
        for (int lvl = 0; lvl < 4; lvl++) begin
            strap_lvl = 2'(lvl);
            do_reset();
            strobe();
            chk("R2 readback", int'(strap_rb), rb_of(lvl));
            step();
            chk("R4 strap depth", int'(depth), rb_of(lvl));
            ramp(2 * N, mult_of(rb_of(lvl)), "R6 ramp");
        end

        // Main scenario: strap mid
        strap_lvl = 2'b01;
        do_reset();
        strobe();
        step();
        sw_code = 2'b11;
        step();
        chk("R4 code ignored", int'(depth), 1);
        strap_lvl = 2'b10;
        strobe();
        step();
        chk("R3 readback kept", int'(strap_rb), 1);
        chk("R3 depth kept", int'(depth), 1);

        ramp(N / 2, 1, "R6 half ramp");
        sw_en = 1'b1;
        step();
        step();
        chk("R8 depth held", int'(depth), 1);
        chk("R8 offset held", int'(offset), -((N / 2) * STEP));
        ramp(2 * N - N / 2, 1, "R8 old depth continues");
        step();
        chk("R8 new depth applied", int'(depth), 3);
        chk("R5 code 11", int'(depth), 3);
        ramp(4 * N, 2, "R6 deep ramp");

        sw_code = 2'b10;
        step();
        chk("R5 reserved code", int'(depth), 0);
        ramp(2 * N, 0, "R9 off");
        sw_code = 2'b01;
        step();
        chk("R5 code 01", int'(depth), 1);
        sw_code = 2'b00;
        step();
        chk("R5 code 00", int'(depth), 0);
        sw_code = 2'b11;
        sw_en = 1'b0;
        step();
        chk("R4 back to strap", int'(depth), 1);
        ramp(N, 1, "R7 bounded");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule